// File: doc/BRIEF.md
# Fault Shutdown Sequencer for a Half-Bridge Driver

This block is the protection sequencer of a half-bridge gate driver. It takes an overcurrent comparator trip bit, which may be asynchronous, and the sensed level of a shared active-low shutdown line. The line is seen through two digital flags that stand for a Schmitt input: one says the line is under the lower threshold and one says it is over the upper threshold. The block drives an open-drain pull-down enable back onto that line. It also drives a single gate-disable signal that forces both gate outputs of the output stage low.

A trip disables the gates on the very next clock edge through a direct path. This path does not wait for the line to discharge. In parallel, the synchronised trip turns on the pull-down, which holds the line low until the line is seen under the lower threshold. The pull-down then lets go, and the external RC network sets how long the line takes to climb back over the upper threshold. The gates stay disabled for that whole time, so the external network alone sets the post-fault disable time. A low level forced onto the line from outside is never latched, so the line can be used to chop the gate outputs like a PWM gate.

Top module: `fault_shutdown`

## Requirements
- R1: While reset is applied and right after it, gateDisable is 1 and pullDownEn is 0. The line is then treated as low until lineAboveHigh is seen.
- R2: A trip sampled high on a clock edge sets gateDisable at that same edge, which is the next cycle. This happens whatever the line flags show.
- R3: pullDownEn rises on the third edge after the first edge that samples the trip (a two-stage synchroniser plus the hold register). It rises only if lineBelowLow is 0 on that edge.
- R4: Once on, pullDownEn stays on until an edge samples lineBelowLow high. It drops at that edge.
- R5: lineBelowLow sampled high on an edge sets gateDisable at that edge. gateDisable then stays 1 while neither flag is set.
- R6: With no trip pending and the pull-down off, an edge that samples lineAboveHigh high (and lineBelowLow low) clears gateDisable at that edge. No external low level is remembered, so repeated low/high cycles on the line chop the gates each time.
- R7: A new trip that arrives while pullDownEn is on does not extend the hold. pullDownEn still drops on the first edge that samples lineBelowLow.
- R8: After a fault, gateDisable stays 1 from the trip until lineAboveHigh is sampled, however long that takes. A longer wait never delays the one-cycle turn-off of R2.
- R9: If both line flags are sampled high together, lineBelowLow wins and gateDisable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tripRaw | input | 1 | Comparator overcurrent trip, may be asynchronous |
| lineBelowLow | input | 1 | Shutdown line sensed under the lower threshold |
| lineAboveHigh | input | 1 | Shutdown line sensed over the upper threshold |
| pullDownEn | output | 1 | Enables the open-drain pull-down on the shutdown line |
| gateDisable | output | 1 | Forces both gate outputs low when 1 |

## Verification
gateDisable is due on the first edge that samples a trip, a low line or a high line. pullDownEn is due three edges after a trip, because of the two synchroniser flops and the hold flop, and it drops on the edge that samples the lower-threshold flag. The bench applies each stimulus just after a falling edge. It queues the outputs expected after the next rising edge, and a monitor compares them at the following falling edge. Each entry in the queue therefore stands for exactly one rising edge, counted from when the stimulus was applied.

// File: rtl/shut_pkg.sv
package shut_pkg;

  // One-cycle commands from the control logic to the state registers
  typedef struct packed {
    logic holdSet;   // start pulling the shared line low
    logic holdClr;   // release the pull-down
    logic lowEnter;  // line seen under the lower threshold
    logic lowLeave;  // line seen over the upper threshold
  } shutStrobesT;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripRaw,
  output logic tripSynced,
  output logic tripAny
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] syncQ;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= tripRaw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign tripSynced = syncQ[LAST];
  // The raw bit and every stage feed the direct disable path, so no cycle goes uncovered
  assign tripAny    = tripRaw | (|syncQ);
endmodule

// File: rtl/shut_ctrl.sv
module shut_ctrl
  import shut_pkg::*;
(
  input  logic        tripSynced,
  input  logic        lineBelowLow,
  input  logic        lineAboveHigh,
  input  logic        holdQ,
  input  logic        lineLowQ,
  output shutStrobesT strobes
);
  always_comb begin
    strobes = '0;
    // A trip only needs the pull-down if the line is not already low
    strobes.holdSet  = !holdQ && tripSynced && !lineBelowLow;
    // Release once the line has crossed the lower threshold; a new trip restarts nothing
    strobes.holdClr  = holdQ && lineBelowLow;
    // Hysteresis: the lower flag enters, only the upper flag leaves, lower wins a tie
    strobes.lowEnter = !lineLowQ && lineBelowLow;
    strobes.lowLeave = lineLowQ && lineAboveHigh && !lineBelowLow;
  end
endmodule

// File: rtl/shut_datapath.sv
module shut_datapath
  import shut_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  shutStrobesT strobes,
  input  logic        tripAny,
  output logic        holdQ,
  output logic        lineLowQ,
  output logic        gateDisable
);
  logic holdNext;
  logic lowNext;

  always_comb begin
    holdNext = strobes.holdSet | (holdQ & ~strobes.holdClr);
    lowNext  = strobes.lowEnter | (lineLowQ & ~strobes.lowLeave);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ       <= 1'b0;
      lineLowQ    <= 1'b1;
      gateDisable <= 1'b1;
    end else begin
      holdQ       <= holdNext;
      lineLowQ    <= lowNext;
      gateDisable <= tripAny | holdNext | lowNext;
    end
  end
endmodule

// File: rtl/fault_shutdown.sv
module fault_shutdown
  import shut_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripRaw,
  input  logic lineBelowLow,
  input  logic lineAboveHigh,
  output logic pullDownEn,
  output logic gateDisable
);
  logic        tripSynced;
  logic        tripAny;
  logic        holdQ;
  logic        lineLowQ;
  shutStrobesT strobes;

  trip_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .tripRaw(tripRaw),
    .tripSynced(tripSynced), .tripAny(tripAny)
  );

  shut_ctrl uCtrl (
    .tripSynced(tripSynced), .lineBelowLow(lineBelowLow),
    .lineAboveHigh(lineAboveHigh), .holdQ(holdQ),
    .lineLowQ(lineLowQ), .strobes(strobes)
  );

  shut_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tripAny(tripAny),
    .holdQ(holdQ), .lineLowQ(lineLowQ), .gateDisable(gateDisable)
  );

  assign pullDownEn = holdQ;

  // R2
  trip_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    tripRaw |=> gateDisable);

  // R5
  low_line_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineBelowLow |=> gateDisable);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullDownEn && lineBelowLow) |=> !pullDownEn);

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullDownEn && !lineBelowLow) |=> pullDownEn);

  // R3
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullDownEn) |-> $past(tripSynced));

  // R8
  hold_disables_chk: assert property (@(posedge clk) disable iff (!rstN)
    pullDownEn |-> gateDisable);
endmodule

// File: tb/tb_fault_shutdown.sv
module tb_fault_shutdown;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tripRaw = 1'b0;
  logic lineBelowLow = 1'b0;
  logic lineAboveHigh = 1'b0;
  logic pullDownEn;
  logic gateDisable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  gd;
    logic  pd;
    string tag;
  } expT;
  expT sb[$];

  always #10 clk = ~clk;  // 50 MHz

  fault_shutdown dut (
    .clk(clk), .rstN(rstN), .tripRaw(tripRaw),
    .lineBelowLow(lineBelowLow), .lineAboveHigh(lineAboveHigh),
    .pullDownEn(pullDownEn), .gateDisable(gateDisable)
  );

  task automatic check(input string tag, input logic gd, input logic pd);
    checks++;
    if (gateDisable !== gd || pullDownEn !== pd) begin
      errors++;
      $display("FAIL %s: gateDisable=%b pullDownEn=%b expected %b %b",
               tag, gateDisable, pullDownEn, gd, pd);
    end
  endtask

  // Apply inputs after a falling edge; expect outputs after the next rising edge
  task automatic step(input logic t, input logic bl, input logic ah,
                      input logic gd, input logic pd, input string tag);
    expT e;
    @(negedge clk);
    #1;
    tripRaw = t; lineBelowLow = bl; lineAboveHigh = ah;
    e.gd = gd; e.pd = pd; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: each queued item belongs to the rising edge just passed
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        expT e;
        e = sb.pop_front();
        check(e.tag, e.gd, e.pd);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1, 1'b0);
    rstN = 1'b1;
    step(0, 0, 0, 1, 0, "R1 after reset line treated low");
    // R6: line goes high, gates enabled
    step(0, 0, 1, 0, 0, "R6 release");
    step(0, 0, 1, 0, 0, "R6 idle");
    // R2/R3/R4/R8: one-cycle trip pulse, line high
    step(1, 0, 1, 1, 0, "R2 trip next cycle");
    step(0, 0, 1, 1, 0, "R3 sync stage");
    step(0, 0, 1, 1, 1, "R3 pull-down on");
    step(0, 0, 1, 1, 1, "R4 held while line high");
    step(0, 0, 0, 1, 1, "R4 held between thresholds");
    step(0, 1, 0, 1, 0, "R4 release at lower threshold");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, "R8 long disable");
    step(0, 0, 1, 0, 0, "R8 re-enable on upper threshold");
    // R8: short disable window, held trip
    step(1, 0, 1, 1, 0, "R2 held trip");
    step(1, 0, 1, 1, 0, "R3 sync");
    step(1, 0, 1, 1, 1, "R3 pull-down on held trip");
    step(0, 1, 0, 1, 0, "R4 release");
    step(0, 1, 0, 1, 0, "R4 stay released");
    step(0, 1, 0, 1, 0, "R4 sync drained");
    step(0, 0, 1, 0, 0, "R8 short window re-enable");
    // R7: second trip during hold
    step(1, 0, 1, 1, 0, "R7 first trip");
    step(0, 0, 1, 1, 0, "R7 sync");
    step(0, 0, 1, 1, 1, "R7 hold on");
    step(1, 0, 0, 1, 1, "R7 second trip during hold");
    step(0, 0, 0, 1, 1, "R7 hold kept");
    step(0, 1, 0, 1, 0, "R7 hold ends on lower threshold");
    step(0, 1, 0, 1, 0, "R7 no restart");
    step(0, 0, 1, 0, 0, "R7 recover");
    // R3: trip while line already low -> no pull-down
    step(0, 1, 0, 1, 0, "R5 external low");
    step(1, 1, 0, 1, 0, "R3 trip on low line");
    step(0, 1, 0, 1, 0, "R3 no pull-down");
    step(0, 1, 0, 1, 0, "R3 no pull-down after sync");
    step(0, 0, 1, 0, 0, "R6 recover");
    // R6: chopping via the line, R5 hysteresis gap
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 1, 0, "R5 chop low");
      step(0, 0, 0, 1, 0, "R5 hysteresis hold");
      step(0, 0, 1, 0, 0, "R6 chop high");
    end
    // R9: both flags
    step(0, 1, 1, 1, 0, "R9 lower flag wins");
    step(0, 0, 1, 0, 0, "R9 recover");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule